// File: doc/BRIEF.md
# Masked Prefix Adder (Three-Share, Pipelined)

This block adds two W-bit operands modulo 2^W while both stay split into three Boolean shares: the true value of each operand is the XOR of its three share words, and the block never recombines them. The sum also leaves as three shares. The design follows a parallel-prefix carry structure built from threshold-style shared functions. Every non-linear shared function feeds a register, so glitches cannot combine shares across the function boundary.

The structure has three parts. A first register stage forms shared generate and propagate bits, and spends one fresh random bit per bit position as a virtual share. Then come log2(W) prefix-combine stages, each registered. These stages use no further randomness, because one share of the lower generate masks the shared propagate product. Last, a share-wise XOR of the delayed propagate and the shifted carries gives the sum.

The pipeline takes one operand pair per cycle. Both edges follow a valid/ready handshake with a single global stall. A word is accepted on an edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` is low.

Top module: `ksa_ti_adder`

## Requirements
- R1: When `out_valid` is high, out_s0^out_s1^out_s2 equals (A+B) mod 2^W. Here A = in_a0^in_a1^in_a2 and B = in_b0^in_b1^in_b2 are the values of the accepted pair.
- R2: With `out_ready` held high, a pair accepted on clock edge E appears with `out_valid` high after edge E+log2(W). For W=32 that is edge E+5, which makes six register stages in total.
- R3: With `out_ready` held high, `in_ready` stays high, pairs are accepted on consecutive edges, and results leave on consecutive edges.
- R4: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next edge `out_valid` and all three sum shares keep their values.
- R5: The unmasked result does not depend on how the operands are split into shares or on the value of `in_rnd`. This includes all-zero shares and all-zero randomness.
- R6: Carries propagate across the full width and wrap modulo 2^W. For W=32: 0x7FFFFFFF+1 = 0x80000000, 0xFFFFFFFF+1 = 0, and 0xFFFFFFFF+0xFFFFFFFF = 0xFFFFFFFE.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: A word offered while `in_ready` is low, or any cycle with `in_valid` low, produces no result. The number of results equals the number of accepted pairs.
- R9: With W=8, the block has three combine stages and a latency of three edges as in R2. It adds all 65536 operand pairs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| in_a0 | input | W | Operand A, share 0 |
| in_a1 | input | W | Operand A, share 1 |
| in_a2 | input | W | Operand A, share 2 |
| in_b0 | input | W | Operand B, share 0 |
| in_b1 | input | W | Operand B, share 1 |
| in_b2 | input | W | Operand B, share 2 |
| in_rnd | input | W | Fresh random bits, one per bit position |
| out_valid | output | 1 | Sum shares valid |
| out_ready | input | 1 | Consumer takes the sum |
| out_s0 | output | W | Sum share 0 |
| out_s1 | output | W | Sum share 1 |
| out_s2 | output | W | Sum share 2 |

## Verification
Assertions check the following on every cycle:
- The unmasked generate and propagate of every register stage match the plain prefix recurrence applied to the previous stage's unmasked values.
- A valid word advances one stage per unstalled edge.
- A stall freezes stage contents and the output.
- The final stage never shows full-span generate and propagate together.

Only the bench scenarios can show the following:
- The end-to-end sum.
- The exact latency in edges.
- That results do not depend on share splits and randomness.
- That back-to-back throughput holds.
- That nothing is emitted for refused or idle cycles.

// File: rtl/ksa_ti_pkg.sv
package ksa_ti_pkg;
  localparam int NSH = 3;

  // Three-share AND with one virtual share m; XOR of the result equals x&y.
  function automatic logic [NSH-1:0] ti_and_vs(input logic [NSH-1:0] x,
                                              input logic [NSH-1:0] y,
                                              input logic m);
    logic [NSH-1:0] r;
    r[0] = (x[1] & y[1]) ^ (x[1] & y[2]) ^ (x[2] & y[1]) ^ m;
    r[1] = (x[2] & y[2]) ^ (x[0] & y[2]) ^ (x[2] & y[0]) ^ (x[0] & m) ^ (y[0] & m);
    r[2] = (x[0] & y[0]) ^ (x[0] & y[1]) ^ (x[1] & y[0]) ^ (x[0] & m) ^ (y[0] & m) ^ m;
    return r;
  endfunction

  // Three-share h ^ (l & q); every output share omits one input share index.
  function automatic logic [NSH-1:0] ti_gen_comb(input logic [NSH-1:0] h,
                                                input logic [NSH-1:0] l,
                                                input logic [NSH-1:0] q);
    logic [NSH-1:0] r;
    r[0] = h[1] ^ (l[1] & q[1]) ^ (l[1] & q[2]) ^ (l[2] & q[1]);
    r[1] = h[2] ^ (l[2] & q[2]) ^ (l[0] & q[2]) ^ (l[2] & q[0]);
    r[2] = h[0] ^ (l[0] & q[0]) ^ (l[0] & q[1]) ^ (l[1] & q[0]);
    return r;
  endfunction
endpackage

// File: rtl/ksa_ti_pre.sv
module ksa_ti_pre
  import ksa_ti_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    vin,
  input  logic [W-1:0][NSH-1:0]   a,
  input  logic [W-1:0][NSH-1:0]   b,
  input  logic [W-1:0]            rnd,
  output logic                    vout,
  output logic [W-1:0][NSH-1:0]   g_q,
  output logic [W-1:0][NSH-1:0]   p_q
);
  logic [W-1:0][NSH-1:0] g_d, p_d;
  logic [W-1:0] a_u, b_u, g_u, p_u;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g_d[i] = ti_and_vs(a[i], b[i], rnd[i]);
    assign p_d[i] = a[i] ^ b[i];
    assign a_u[i] = ^a[i];
    assign b_u[i] = ^b[i];
    assign g_u[i] = ^g_q[i];
    assign p_u[i] = ^p_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vout <= 1'b0;
    else if (adv) vout <= vin;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      g_q <= g_d;
      p_q <= p_d;
    end
  end

  // R1: shared generate/propagate reconstruct to a&b and a^b
  p_gen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv && vin |=> (g_u == $past(a_u & b_u)) && (p_u == $past(a_u ^ b_u)));
  // R8: a cycle without a valid word leaves no valid word in the stage
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !vin |=> !vout);
endmodule

// File: rtl/ksa_ti_stage.sv
module ksa_ti_stage
  import ksa_ti_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    vin,
  input  logic [W-1:0][NSH-1:0]   g_in,
  input  logic [W-1:0][NSH-1:0]   p_in,
  output logic                    vout,
  output logic [W-1:0][NSH-1:0]   g_q,
  output logic [W-1:0][NSH-1:0]   p_q
);
  logic [W-1:0][NSH-1:0] g_d, p_d;
  logic [W-1:0] gi_u, pi_u, ref_g, ref_p, go_u, po_u;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gi_u[i] = ^g_in[i];
    assign pi_u[i] = ^p_in[i];
    assign go_u[i] = ^g_q[i];
    assign po_u[i] = ^p_q[i];
    if (i >= DIST) begin : g_pair
      assign g_d[i]   = ti_gen_comb(g_in[i], g_in[i-DIST], p_in[i]);
      assign p_d[i]   = ti_and_vs(p_in[i], p_in[i-DIST], g_in[i-DIST][0]);
      assign ref_g[i] = gi_u[i] ^ (gi_u[i-DIST] & pi_u[i]);
      assign ref_p[i] = pi_u[i] & pi_u[i-DIST];
    end else begin : g_pass
      assign g_d[i]   = g_in[i];
      assign p_d[i]   = p_in[i];
      assign ref_g[i] = gi_u[i];
      assign ref_p[i] = pi_u[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vout <= 1'b0;
    else if (adv) vout <= vin;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      g_q <= g_d;
      p_q <= p_d;
    end
  end

  // R1: unmasked stage output follows the plain prefix recurrence
  p_comb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv && vin |=> (go_u == $past(ref_g)) && (po_u == $past(ref_p)));
  // R2: a valid word moves forward one stage per unstalled edge
  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv && vin |=> vout);
  // R4: a stall freezes stage contents
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && vout |=> vout && $stable(g_q) && $stable(p_q));
endmodule

// File: rtl/ksa_ti_delay.sv
module ksa_ti_delay
  import ksa_ti_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic                    clk,
  input  logic                    adv,
  input  logic [W-1:0][NSH-1:0]   d,
  output logic [W-1:0][NSH-1:0]   q
);
  logic [W-1:0][NSH-1:0] tap [DEPTH+1];

  assign tap[0] = d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (adv) tap[k+1] <= tap[k];
    end
  end

  assign q = tap[DEPTH];
endmodule

// File: rtl/ksa_ti_adder.sv
module ksa_ti_adder
  import ksa_ti_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a0,
  input  logic [W-1:0] in_a1,
  input  logic [W-1:0] in_a2,
  input  logic [W-1:0] in_b0,
  input  logic [W-1:0] in_b1,
  input  logic [W-1:0] in_b2,
  input  logic [W-1:0] in_rnd,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_s0,
  output logic [W-1:0] out_s1,
  output logic [W-1:0] out_s2
);
  localparam int STAGES = $clog2(W);

  logic                  adv;
  logic [W-1:0][NSH-1:0] a_sh, b_sh, pd, cy;
  logic [W-1:0][NSH-1:0] g_pipe [STAGES+1];
  logic [W-1:0][NSH-1:0] p_pipe [STAGES+1];
  logic [STAGES:0]       v_pipe;
  logic [W-1:0]          gl_u, pl_u, pd_u;

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  for (genvar i = 0; i < W; i++) begin : g_pack
    assign a_sh[i] = {in_a2[i], in_a1[i], in_a0[i]};
    assign b_sh[i] = {in_b2[i], in_b1[i], in_b0[i]};
  end

  ksa_ti_pre #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(adv), .vin(in_valid),
    .a(a_sh), .b(b_sh), .rnd(in_rnd),
    .vout(v_pipe[0]), .g_q(g_pipe[0]), .p_q(p_pipe[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    ksa_ti_stage #(.W(W), .DIST(1 << k)) u_stage (
      .clk(clk), .rst_n(rst_n), .adv(adv), .vin(v_pipe[k]),
      .g_in(g_pipe[k]), .p_in(p_pipe[k]),
      .vout(v_pipe[k+1]), .g_q(g_pipe[k+1]), .p_q(p_pipe[k+1])
    );
  end

  ksa_ti_delay #(.W(W), .DEPTH(STAGES)) u_pdly (
    .clk(clk), .adv(adv), .d(p_pipe[0]), .q(pd)
  );

  // carry into bit i is the full-prefix generate of bit i-1; carry in is zero
  assign cy[0]     = '0;
  assign cy[W-1:1] = g_pipe[STAGES][W-2:0];

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign out_s0[i] = pd[i][0] ^ cy[i][0];
    assign out_s1[i] = pd[i][1] ^ cy[i][1];
    assign out_s2[i] = pd[i][2] ^ cy[i][2];
    assign gl_u[i]   = ^g_pipe[STAGES][i];
    assign pl_u[i]   = ^p_pipe[STAGES][i];
    assign pd_u[i]   = ^pd[i];
  end

  assign out_valid = v_pipe[STAGES];

  // R4: a waiting result blocks the input and holds the output
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_s0) && $stable(out_s1) && $stable(out_s2));
  // R1: full-span propagate and generate exclude each other; span covers every bit
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(gl_u[W-1] && pl_u[W-1]));
  p_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pl_u[W-1] == (&pd_u)));
endmodule

// File: tb/ksa_ti_adder_tb.sv
module ksa_ti_adder_tb;
  localparam int W    = 32;
  localparam int LAT  = $clog2(W);
  localparam int W8   = 8;
  localparam int LAT8 = $clog2(W8);
  localparam int QN   = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, in_ready, out_valid;
  logic [W-1:0] a0 = '0, a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0, rnd = '0;
  logic [W-1:0] s0, s1, s2;

  logic v8 = 1'b0, ordy8 = 1'b0, ir8, ov8;
  logic [W8-1:0] x0 = '0, x1 = '0, x2 = '0, y0 = '0, y1 = '0, y2 = '0, rnd8 = '0;
  logic [W8-1:0] t0, t1, t2;

  ksa_ti_adder #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a0(a0), .in_a1(a1), .in_a2(a2), .in_b0(b0), .in_b1(b1), .in_b2(b2),
    .in_rnd(rnd), .out_valid(out_valid), .out_ready(out_ready),
    .out_s0(s0), .out_s1(s1), .out_s2(s2)
  );

  ksa_ti_adder #(.W(W8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(ir8),
    .in_a0(x0), .in_a1(x1), .in_a2(x2), .in_b0(y0), .in_b1(y1), .in_b2(y2),
    .in_rnd(rnd8), .out_valid(ov8), .out_ready(ordy8),
    .out_s0(t0), .out_s1(t1), .out_s2(t2)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] exp_q [QN];
  int           acc_q [QN];
  int           tx_q  [QN];
  string        tag_q [QN];
  int  wr = 0, rd = 0, rdy_mode = 0;
  bit  lat_on = 1'b0, held = 1'b0;
  logic [W-1:0] held_v;
  int  rd8 = 0, acc8_first = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit zmask, input string tag);
    logic [W-1:0] r1, r2, r3, r4;
    bit got;
    r1 = zmask ? '0 : $urandom;
    r2 = zmask ? '0 : $urandom;
    r3 = zmask ? '0 : $urandom;
    r4 = zmask ? '0 : $urandom;
    @(negedge clk); #1;
    a0 = r1; a1 = r2; a2 = a ^ r1 ^ r2;
    b0 = r3; b1 = r4; b2 = b ^ r3 ^ r4;
    rnd = zmask ? '0 : $urandom;
    in_valid = 1'b1;
    got = 1'b0;
    while (!got) begin
      #2;
      if (in_ready) begin
        exp_q[wr] = a + b;
        acc_q[wr] = cyc + 1;
        tag_q[wr] = tag;
        wr++;
        got = 1'b1;
      end else begin
        @(negedge clk); #1;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (rd < wr && n < 2000) begin
      @(posedge clk);
      n++;
    end
    chk(rd == wr, "R8 result count", W'(rd), W'(wr));
  endtask

  always @(negedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor for the 32-bit instance, one time unit before each rising edge
  always begin
    @(negedge clk); #3;
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (held) chk((s0 ^ s1 ^ s2) == held_v, "R4 held output", s0 ^ s1 ^ s2, held_v);
        if (out_ready) begin
          held = 1'b0;
          if (rd >= wr) begin
            chk(1'b0, "R8 unexpected result", s0 ^ s1 ^ s2, '0);
          end else begin
            chk((s0 ^ s1 ^ s2) == exp_q[rd], tag_q[rd], s0 ^ s1 ^ s2, exp_q[rd]);
            if (lat_on) chk(cyc - acc_q[rd] == LAT, "R2 latency", W'(cyc - acc_q[rd]), W'(LAT));
            tx_q[rd] = cyc + 1;
            rd++;
          end
        end else begin
          chk(!in_ready, "R4 in_ready low while stalled", W'(in_ready), '0);
          held   = 1'b1;
          held_v = s0 ^ s1 ^ s2;
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  // monitor for the 8-bit instance: results arrive in operand-index order
  always begin
    @(negedge clk); #3;
    if (rst_n && !finished && ov8 && ordy8) begin
      logic [W8-1:0] ea, eb, es;
      ea = rd8[15:8];
      eb = rd8[7:0];
      es = ea + eb;
      chk((t0 ^ t1 ^ t2) == es, "R9 sum", W'(t0 ^ t1 ^ t2), W'(es));
      if (rd8 == 0) chk(cyc - acc8_first == LAT8, "R9 latency", W'(cyc - acc8_first), W'(LAT8));
      rd8++;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    #2;
    chk(!out_valid, "R7 out_valid after reset", W'(out_valid), '0);
    chk(in_ready, "R7 in_ready after reset", W'(in_ready), 1);
    chk(!ov8, "R7 out_valid after reset (W=8)", W'(ov8), '0);

    // single carry-chain word into an empty pipeline: latency and value
    rdy_mode = 0;
    lat_on   = 1'b1;
    send(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R6 carry chain");
    idle();
    drain();

    // back-to-back carry corners
    base = wr;
    send(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6 wrap to zero");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6 all ones");
    send(32'h0000_0000, 32'h0000_0000, 1'b0, "R6 zero");
    send(32'h8000_0000, 32'h8000_0000, 1'b0, "R6 top carry out");
    send(32'h5555_5555, 32'hAAAA_AAAB, 1'b0, "R6 alternating chain");
    send(32'h0000_0001, 32'hFFFF_FFFE, 1'b0, "R6 no carry");
    idle();
    drain();
    for (int k = base + 1; k < base + 6; k++) begin
      chk(acc_q[k] == acc_q[k-1] + 1, "R3 consecutive accepts", W'(acc_q[k]), W'(acc_q[k-1] + 1));
      chk(tx_q[k] == tx_q[k-1] + 1, "R3 consecutive results", W'(tx_q[k]), W'(tx_q[k-1] + 1));
    end

    // same operands, different share splits and randomness
    send(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R5 zero masks");
    for (int k = 0; k < 4; k++) send(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R5 random masks");
    send(32'hDEAD_BEEF, 32'h2152_4111, 1'b1, "R5 zero masks carry");
    idle();
    drain();
    lat_on = 1'b0;

    // fill under stall, then offer a word that must be refused
    rdy_mode = 2;
    for (int k = 0; k < LAT + 1; k++) send($urandom, $urandom, 1'b0, "R8 stalled fill");
    @(negedge clk); #1;
    a0 = 32'hFFFF_0000; a1 = '0; a2 = '0; b0 = 32'h0000_FFFF; b1 = '0; b2 = '0;
    in_valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #2;
      chk(!in_ready, "R8 refused while full", W'(in_ready), '0);
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
    rdy_mode = 0;
    drain();
    repeat (4) @(posedge clk);
    #1;
    chk(!out_valid, "R8 nothing after drain", W'(out_valid), '0);

    // random stream with random back-pressure
    rdy_mode = 1;
    for (int k = 0; k < 1500; k++) send($urandom, $urandom, ($urandom % 8) == 0, "R1 random sum");
    idle();
    rdy_mode = 0;
    drain();

    // exhaustive 8-bit configuration
    @(negedge clk); #1;
    ordy8 = 1'b1;
    for (int k = 0; k < 65536; k++) begin
      logic [W8-1:0] va, vb, m1, m2, m3, m4;
      if (k != 0) begin
        @(negedge clk); #1;
      end
      va = k[15:8]; vb = k[7:0];
      m1 = $urandom; m2 = $urandom; m3 = $urandom; m4 = $urandom;
      x0 = m1; x1 = m2; x2 = va ^ m1 ^ m2;
      y0 = m3; y1 = m4; y2 = vb ^ m3 ^ m4;
      rnd8 = $urandom;
      v8 = 1'b1;
      #2;
      if (k == 0) acc8_first = cyc + 1;
      chk(ir8, "R3 in_ready held (W=8)", W'(ir8), 1);
    end
    @(negedge clk); #1;
    v8 = 1'b0;
    repeat (LAT8 + 4) @(posedge clk);
    #1;
    chk(rd8 == 65536, "R9 result count", W'(rd8), W'(65536));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule